// File: doc/BRIEF.md
# Shader Code Upload Port with Broadcast

This block sits behind a write-only register port and loads shader program words and swizzle-pattern words into the memories of two shader units. One is a vertex unit and the other is a unit that can run geometry work. There are four upload targets: vertex program, vertex swizzle, geometry program and geometry swizzle. Each target has its own offset register. Writing a data word stores it at the target's current offset and then advances that offset by one. A separate address for each target loads its offset directly.

A configuration bit can give the geometry-capable unit its own private setup. While that bit is clear, every accepted vertex program or vertex swizzle word is also stored at the same offset in the matching geometry memory. The geometry unit's own offsets do not move when this happens.

A write whose offset is already at or past the end of its memory is dropped, and the offset stays where it was. The block reports each dropped write with a one-cycle error pulse that carries the target's identity. A combinational read port lets a test environment inspect any of the four memories.

Top module: `shader_code_loader`

## Requirements
- R1: Each target takes data on any of eight consecutive addresses, all eight behaving identically. The windows are vertex program 0x2CC–0x2D3, vertex swizzle 0x2D6–0x2DD, geometry program 0x29C–0x2A3 and geometry swizzle 0x2A6–0x2AD.
- R2: An accepted data write stores `wr_data` at the target's current offset, and that offset then increases by one.
- R3: Memory depths are 512 words for vertex program, 4096 words for geometry program and `SWZ_DEPTH` words (default 128) for each swizzle memory. The bounds check for each target uses its own depth.
- R4: A data write whose offset is greater than or equal to the target depth stores nothing and leaves the offset unchanged.
- R5: While the exclusive bit is 0, an accepted vertex program write is also stored in geometry program memory at the same offset.
- R6: While the exclusive bit is 0, an accepted vertex swizzle write is also stored in geometry swizzle memory at the same offset.
- R7: The exclusive bit is bit 0 of the configuration register at address 0x232, and the other bits of that write are ignored. When the bit is 1, vertex writes are not copied.
- R8: Mirrored copies do not change the geometry offsets. A later geometry data write still lands at the geometry unit's own offset.
- R9: The offset-set addresses (0x2CB vertex program, 0x2D5 vertex swizzle, 0x29B geometry program, 0x2A5 geometry swizzle) load the offset from `wr_data[OFF_W-1:0]` and write no memory.
- R10: A rejected write raises `err_valid` for exactly the one cycle after its clock edge. `err_target` is then 0 for vertex program, 1 for vertex swizzle, 2 for geometry program and 3 for geometry swizzle.
- R11: `rd_data` shows, combinationally, the word at `rd_addr` in the memory that `rd_target` selects, using the same encoding as R10.
- R12: Reset clears all four offsets and the exclusive bit, and holds `err_valid` low.
- R13: A write to any other address changes no memory, no offset and no configuration, and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 10 | Register address |
| wr_data | input | DATA_W | Write data |
| err_valid | output | 1 | Pulse for a rejected data write |
| err_target | output | 2 | Target of the rejected write |
| rd_target | input | 2 | Memory selected for inspection |
| rd_addr | input | OFF_W | Word index for inspection |
| rd_data | output | DATA_W | Word read from the selected memory |

## Verification
Memory contents, offsets and the exclusive bit all change on the clock edge that samples the write. `err_valid` and `err_target` are registered once, so they are valid during the cycle after that edge. The bench drives each write at a falling edge and samples the error outputs at the next falling edge, which lies inside that one-cycle window. Memory contents are read through the combinational read port only while the write strobe is low, one nanosecond after the read address changes. All data, including the words copied into the geometry memories, is compared against a bench model of the four memories and offsets.

// File: rtl/ld_pkg.sv
package ld_pkg;
    localparam int REG_AW  = 10;
    localparam int NUM_TGT = 4;
    localparam int ALIASES = 8;
    localparam logic [REG_AW-1:0] CFG_ADDR = 10'h232;

    typedef enum logic [1:0] {
        TGT_VS_PROG = 2'd0,
        TGT_VS_SWZ  = 2'd1,
        TGT_GS_PROG = 2'd2,
        TGT_GS_SWZ  = 2'd3
    } ld_tgt_e;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_DATA   = 2'd1,
        OP_SETOFF = 2'd2,
        OP_CFG    = 2'd3
    } ld_op_e;

    typedef struct packed {
        ld_op_e  op;
        ld_tgt_e tgt;
    } ld_cmd_t;

    // Last address of each target's data window; the offset-set register sits just below the window.
    function automatic logic [REG_AW-1:0] win_last(ld_tgt_e t);
        case (t)
            TGT_VS_PROG: win_last = 10'h2d3;
            TGT_VS_SWZ:  win_last = 10'h2dd;
            TGT_GS_PROG: win_last = 10'h2a3;
            default:     win_last = 10'h2ad;
        endcase
    endfunction

    function automatic ld_cmd_t decode_addr(logic [REG_AW-1:0] a);
        ld_cmd_t c;
        logic [REG_AW-1:0] last;
        c.op  = OP_NONE;
        c.tgt = TGT_VS_PROG;
        if (a == CFG_ADDR) c.op = OP_CFG;
        for (int i = 0; i < NUM_TGT; i++) begin
            last = win_last(ld_tgt_e'(i[1:0]));
            if (a <= last && a > last - REG_AW'(ALIASES)) begin
                c.op  = OP_DATA;
                c.tgt = ld_tgt_e'(i[1:0]);
            end else if (a == last - REG_AW'(ALIASES)) begin
                c.op  = OP_SETOFF;
                c.tgt = ld_tgt_e'(i[1:0]);
            end
        end
        return c;
    endfunction
endpackage

// File: rtl/ld_decode.sv
module ld_decode
    import ld_pkg::*;
(
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    output ld_cmd_t           cmd,
    output logic              vs_hit
);
    ld_cmd_t raw;

    always_comb begin
        raw = decode_addr(wr_addr);
        cmd = raw;
        if (!wr_en) cmd.op = OP_NONE;
        vs_hit = (cmd.op == OP_DATA || cmd.op == OP_SETOFF) &&
                 (cmd.tgt == TGT_VS_PROG || cmd.tgt == TGT_VS_SWZ);
    end
endmodule

// File: rtl/ld_offset_ctr.sv
module ld_offset_ctr #(
    parameter int DEPTH = 512,
    parameter int OFF_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             data_we,
    input  logic             set_we,
    input  logic [OFF_W-1:0] set_val,
    output logic [OFF_W-1:0] offset,
    output logic             accept,
    output logic             reject
);
    localparam logic [OFF_W-1:0] LIMIT = OFF_W'(DEPTH);

    logic in_range;

    always_comb begin
        in_range = offset < LIMIT;
        accept   = data_we && in_range;
        reject   = data_we && !in_range;
    end

    always_ff @(posedge clk) begin
        if (rst)         offset <= '0;
        else if (set_we) offset <= set_val;
        else if (accept) offset <= offset + OFF_W'(1);
    end
endmodule

// File: rtl/ld_wordmem.sv
module ld_wordmem #(
    parameter int DEPTH  = 512,
    parameter int OFF_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [OFF_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [OFF_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [OFF_W-1:0] LIMIT = OFF_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && waddr < LIMIT) mem[waddr[AW-1:0]] <= wdata;
    end

    always_comb begin
        rdata = (raddr < LIMIT) ? mem[raddr[AW-1:0]] : '0;
    end
endmodule

// File: rtl/shader_code_loader.sv
module shader_code_loader
    import ld_pkg::*;
#(
    parameter int VS_PROG_DEPTH = 512,
    parameter int GS_PROG_DEPTH = 4096,
    parameter int SWZ_DEPTH     = 128,
    parameter int OFF_W         = 16,
    parameter int DATA_W        = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              err_valid,
    output logic [1:0]        err_target,
    input  logic [1:0]        rd_target,
    input  logic [OFF_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    ld_cmd_t cmd;
    logic    vs_hit;
    logic    excl_q;
    logic    [NUM_TGT-1:0] data_we, set_we, acc, rej;
    logic    [NUM_TGT-1:0][OFF_W-1:0] off_q;
    logic    [DATA_W-1:0] rdata_arr [NUM_TGT];
    logic    [1:0] mir;
    ld_tgt_e rej_idx;

    ld_decode u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .cmd     (cmd),
        .vs_hit  (vs_hit)
    );

    always_comb begin
        for (int i = 0; i < NUM_TGT; i++) begin
            data_we[i] = (cmd.op == OP_DATA)   && (cmd.tgt == ld_tgt_e'(i[1:0]));
            set_we[i]  = (cmd.op == OP_SETOFF) && (cmd.tgt == ld_tgt_e'(i[1:0]));
        end
        // vertex-side words are copied to the geometry side unless it is configured exclusively
        mir[0] = acc[TGT_VS_PROG] && !excl_q;
        mir[1] = acc[TGT_VS_SWZ]  && !excl_q;
        rej_idx = TGT_VS_PROG;
        for (int i = 0; i < NUM_TGT; i++) begin
            if (rej[i]) rej_idx = ld_tgt_e'(i[1:0]);
        end
    end

    for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgt
        localparam int TD = (g == 0) ? VS_PROG_DEPTH :
                            (g == 2) ? GS_PROG_DEPTH : SWZ_DEPTH;
        logic              m_we;
        logic [OFF_W-1:0]  m_addr;

        ld_offset_ctr #(.DEPTH(TD), .OFF_W(OFF_W)) u_ctr (
            .clk     (clk),
            .rst     (rst),
            .data_we (data_we[g]),
            .set_we  (set_we[g]),
            .set_val (wr_data[OFF_W-1:0]),
            .offset  (off_q[g]),
            .accept  (acc[g]),
            .reject  (rej[g])
        );

        if (g >= 2) begin : g_shared
            assign m_we   = acc[g] || mir[g-2];
            assign m_addr = acc[g] ? off_q[g] : off_q[g-2];
        end else begin : g_own
            assign m_we   = acc[g];
            assign m_addr = off_q[g];
        end

        ld_wordmem #(.DEPTH(TD), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_mem (
            .clk   (clk),
            .we    (m_we),
            .waddr (m_addr),
            .wdata (wr_data),
            .raddr (rd_addr),
            .rdata (rdata_arr[g])
        );
    end

    assign rd_data = rdata_arr[rd_target];

    always_ff @(posedge clk) begin
        if (rst) begin
            excl_q     <= 1'b0;
            err_valid  <= 1'b0;
            err_target <= 2'd0;
        end else begin
            if (cmd.op == OP_CFG) excl_q <= wr_data[0];
            err_valid  <= |rej;
            err_target <= rej_idx;
        end
    end
endmodule

// File: rtl/ld_checks.sv
module ld_checks #(
    parameter int OFF_W = 16
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  err_valid,
    input logic [3:0][OFF_W-1:0] offs,
    input logic [3:0]            acc,
    input logic [3:0]            rej,
    input logic                  vs_hit
);
    for (genvar g = 0; g < 4; g++) begin : g_p
        p_advance_r2: assert property (@(posedge clk) disable iff (rst)
            acc[g] |=> offs[g] == $past(offs[g]) + OFF_W'(1));
        p_hold_on_reject_r4: assert property (@(posedge clk) disable iff (rst)
            rej[g] |=> $stable(offs[g]));
    end

    p_single_target_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(acc | rej));

    p_gs_offsets_still_r8: assert property (@(posedge clk) disable iff (rst)
        vs_hit |=> ($stable(offs[2]) && $stable(offs[3])));

    p_err_follows_reject_r10: assert property (@(posedge clk) disable iff (rst)
        (|rej) |=> err_valid);

    p_err_has_cause_r10: assert property (@(posedge clk) disable iff (rst)
        err_valid |-> $past(|rej));
endmodule

bind shader_code_loader ld_checks #(.OFF_W(OFF_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .err_valid (err_valid),
    .offs      (off_q),
    .acc       (acc),
    .rej       (rej),
    .vs_hit    (vs_hit)
);

// File: tb/sim_shader_code_loader.sv
module sim_shader_code_loader;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [9:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        err_valid;
    logic [1:0]  err_target;
    logic [1:0]  rd_target = '0;
    logic [15:0] rd_addr = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;

    logic [31:0] mdl [4][4096];
    bit          wrt [4][4096];
    int          moff [4];
    bit          mexcl;

    always #10 clk = ~clk;

    shader_code_loader u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .err_valid(err_valid), .err_target(err_target),
        .rd_target(rd_target), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic int dep(int t);
        return (t == 0) ? 512 : (t == 2) ? 4096 : 128;
    endfunction

    // data window last addresses per requirement R1
    function automatic int last_of(int t);
        case (t)
            0: return 'h2d3;
            1: return 'h2dd;
            2: return 'h2a3;
            default: return 'h2ad;
        endcase
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(int addr, logic [31:0] data);
        bit exp_err = 0;
        int exp_tgt = 0;
        bool_decode: begin
            if (addr == 'h232) mexcl = data[0];                      // R7
            for (int t = 0; t < 4; t++) begin
                if (addr <= last_of(t) && addr > last_of(t) - 8) begin   // R1
                    if (moff[t] >= dep(t)) begin                      // R4
                        exp_err = 1; exp_tgt = t;
                    end else begin                                    // R2
                        mdl[t][moff[t]] = data; wrt[t][moff[t]] = 1;
                        if (t < 2 && !mexcl) begin                    // R5 R6
                            mdl[t+2][moff[t]] = data; wrt[t+2][moff[t]] = 1;
                        end
                        moff[t]++;
                    end
                end else if (addr == last_of(t) - 8) begin            // R9
                    moff[t] = int'(data[15:0]);
                end
            end
        end
        @(negedge clk);
        wr_en = 1; wr_addr = addr[9:0]; wr_data = data;
        @(negedge clk);
        wr_en = 0;
        chk(err_valid == exp_err, "R10 err_valid", err_valid, exp_err);
        if (exp_err) chk(err_target == exp_tgt[1:0], "R10 err_target", err_target, exp_tgt);
    endtask

    task automatic cmp_mem(int t, string req);
        int bad = 0;
        int first = -1;
        logic [31:0] got = '0;
        for (int a = 0; a < dep(t); a++) begin
            if (wrt[t][a]) begin
                rd_target = t[1:0]; rd_addr = a[15:0];
                #1;
                if (rd_data !== mdl[t][a]) begin
                    if (first < 0) begin first = a; got = rd_data; end
                    bad++;
                end
            end
        end
        if (first < 0) chk(1, req, 0, 0);
        else chk(0, $sformatf("%s mem%0d addr %0h", req, t, first), got, mdl[t][first]);
    endtask

    task automatic cmp_all();
        cmp_mem(0, "R2 R11 vs_prog");
        cmp_mem(1, "R2 R11 vs_swz");
        cmp_mem(2, "R5 R8 gs_prog");
        cmp_mem(3, "R6 R8 gs_swz");
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int t = 0; t < 4; t++) moff[t] = 0;
        mexcl = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(err_valid == 0, "R12 err_valid after reset", err_valid, 0);

        // R12 excl clear after reset: vertex words mirror
        do_write('h2cc, 32'hA5A5_0001);
        do_write('h2d6, 32'h5A5A_0002);
        cmp_all();

        // R1: every alias of each window
        for (int t = 0; t < 4; t++)
            for (int k = 0; k < 8; k++)
                do_write(last_of(t) - 7 + k, 32'h1000_0000 + t * 16 + k);
        // R8: geometry words land at geometry's own offset despite mirrors
        cmp_all();

        // R7: only bit 0 counts
        do_write('h232, 32'hFFFF_FFFE);
        do_write('h2d0, 32'hBEEF_0003);
        do_write('h232, 32'h0000_0001);
        do_write('h2d0, 32'hBEEF_0004);
        do_write('h2da, 32'hBEEF_0005);
        cmp_all();
        do_write('h232, 32'h0);

        // R3 R4: bounds of each memory, rejection keeps rejecting
        do_write('h2cb, 32'd510);
        for (int k = 0; k < 4; k++) do_write('h2cc, 32'hC000_0000 + k);
        do_write('h29b, 32'd4095);
        for (int k = 0; k < 3; k++) do_write('h29c, 32'hC100_0000 + k);
        do_write('h2d5, 32'd127);
        for (int k = 0; k < 3; k++) do_write('h2d6, 32'hC200_0000 + k);
        do_write('h2a5, 32'd127);
        for (int k = 0; k < 3; k++) do_write('h2a6, 32'hC300_0000 + k);
        cmp_all();

        // R9: setting an offset writes nothing; R13: unmapped addresses do nothing
        do_write('h2cb, 32'd3);
        do_write('h000, 32'hDEAD_0000);
        do_write('h2a4, 32'hDEAD_0001);
        do_write('h2de, 32'hDEAD_0002);
        do_write('h231, 32'hDEAD_0003);
        cmp_all();
        do_write('h2cc, 32'hD000_0009);
        cmp_all();

        // constrained random mix
        for (int n = 0; n < 900; n++) begin
            int r = $urandom % 100;
            int t = $urandom % 4;
            if (r < 65) begin
                do_write(last_of(t) - 7 + ($urandom % 8), $urandom);
            end else if (r < 78) begin
                int v = ($urandom % 2) ? dep(t) - 3 + ($urandom % 6) : $urandom % dep(t);
                do_write(last_of(t) - 8, v);
            end else if (r < 86) begin
                do_write('h232, $urandom);
            end else if (r < 95) begin
                int ua = ($urandom % 2) ? ('h300 + $urandom % 'h100) : ('h2de + $urandom % 'h20);
                do_write(ua, $urandom);
            end else begin
                @(negedge clk);
            end
        end
        cmp_all();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule